// File: doc/BRIEF.md
# Processor Status Register with Flag Arbitration

This block is the 8-bit status register of a small accumulator-style CPU core. It holds three data-memory bank select bits, two reset-cause bits and three arithmetic flags (zero, digit carry, carry). Software reaches it through a data-bus write strobe. The ALU updates the flags through a per-flag update mask and the new values. Power and watchdog logic drive the two reset-cause bits through single-cycle event pulses.

The register is split into three parts, each with its own rules. The bank bits change only on bus writes. The flags take a bus write only when the same instruction does not also update flags; if it does, the ALU result wins for every flag. The reset-cause pair is kept by a four-state machine whose states are named by the pair's value:

- `PW_RUN` (TO=1, PD=1)
- `PW_NAP` (TO=1, PD=0)
- `PW_TMO_RUN` (TO=0, PD=1)
- `PW_TMO_NAP` (TO=0, PD=0)

It has three kinds of transition:

- **Clear transition**: any state goes to `PW_RUN` on a watchdog clear.
- **Nap transition**: any state goes to `PW_NAP` on a sleep event.
- **Timeout transition**: `PW_RUN` goes to `PW_TMO_RUN`, and `PW_NAP` goes to `PW_TMO_NAP`, on a watchdog timeout. The two timeout states stay where they are.

When no event arrives, the state holds. The register value and the decoded bank selects are outputs. Updates appear on the clock edge that samples the request.

Top module: `cpu_status_reg`

## Requirements
- R1: While `rst_n` is low and after its release, `stat_q` reads 8'b0001_1000: bank bits 0, bit 4 (TO) and bit 3 (PD) set, and the three flags modelled as 0.
- R2: A bus write with `flg_upd` all zero loads bits 7:5 and 2:0 from `wr_data` at the sampling edge.
- R3: Bits 4 and 3 never take bus write data; without a power or watchdog event they hold.
- R4: A bus write while any `flg_upd` bit is set leaves all three flags ignoring `wr_data`. Flags whose mask bit (bit2 Z, bit1 DC, bit0 C) is set take `flg_val`; the others hold. The bank bits are still written.
- R5: A flag update without a bus write loads the masked flags from `flg_val` and holds the rest.
- R6: A watchdog clear (`wdt_clr`) without a timeout sets TO and PD to 1.
- R7: A sleep event (`sleep_evt`) alone sets TO to 1 and clears PD.
- R8: A watchdog timeout (`wdt_tmo`) clears TO and keeps PD. It wins over a clear or sleep in the same cycle.
- R9: When a clear and a sleep arrive together without a timeout, the clear wins: TO=1, PD=1.
- R10: `ind_bank_hi` equals bit 7, and `dir_bank` equals bits 6:5.
- R11: With no strobe, mask or event active, every bit of `stat_q` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Data-bus write strobe |
| wr_data | input | 8 | Data-bus write value |
| flg_upd | input | 3 | Flag update mask from the executing instruction (Z, DC, C) |
| flg_val | input | 3 | New flag values from the ALU (Z, DC, C) |
| wdt_clr | input | 1 | Watchdog-clear event pulse |
| sleep_evt | input | 1 | Sleep-entry event pulse |
| wdt_tmo | input | 1 | Watchdog timeout event pulse |
| stat_q | output | 8 | Register value |
| ind_bank_hi | output | 1 | Upper-half bank select for indirect addressing |
| dir_bank | output | 2 | Bank select for direct addressing |

## Verification
Directed patterns come first:
- A plain write with a zero mask shows that all writable bits are loaded.
- A write of zero with only the Z mask set shows that a write suppresses the flag bus data, and reproduces the clear-register result 000u_u1uu.
- A write of all ones with a partial mask separates the masked flags from the held ones.
- Event pulses, alone and in pairs, separate the three transitions and their priority. A paired timeout and clear tells timeout-first from clear-first ordering.

A long run of random combinations of write, mask and events is then checked against a behavioural model on every clock.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int FLAG_W = 3;
    localparam int BANK_W = 3;
    localparam int REG_W  = BANK_W + 2 + FLAG_W;

    // encoding equals {TO, PD}
    typedef enum logic [1:0] {
        PW_TMO_NAP = 2'b00,
        PW_TMO_RUN = 2'b01,
        PW_NAP     = 2'b10,
        PW_RUN     = 2'b11
    } pw_state_e;
endpackage

// File: rtl/stat_pwr_fsm.sv
module stat_pwr_fsm
    import stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wdt_clr,
    input  logic sleep_evt,
    input  logic wdt_tmo,
    output logic to_q,
    output logic pd_q
);
    pw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PW_RUN;
        else        state_q <= state_d;
    end

    // priority: timeout, then clear, then sleep
    always_comb begin
        state_d = state_q;
        if (wdt_tmo) begin
            unique case (state_q)
                PW_RUN:     state_d = PW_TMO_RUN;
                PW_NAP:     state_d = PW_TMO_NAP;
                PW_TMO_RUN: state_d = PW_TMO_RUN;
                PW_TMO_NAP: state_d = PW_TMO_NAP;
                default:    state_d = PW_TMO_RUN;
            endcase
        end else if (wdt_clr) begin
            state_d = PW_RUN;
        end else if (sleep_evt) begin
            state_d = PW_NAP;
        end
    end

    always_comb begin
        unique case (state_q)
            PW_RUN:     begin to_q = 1'b1; pd_q = 1'b1; end
            PW_NAP:     begin to_q = 1'b1; pd_q = 1'b0; end
            PW_TMO_RUN: begin to_q = 1'b0; pd_q = 1'b1; end
            PW_TMO_NAP: begin to_q = 1'b0; pd_q = 1'b0; end
            default:    begin to_q = 1'b1; pd_q = 1'b1; end
        endcase
    end
endmodule

// File: rtl/stat_flag_unit.sv
module stat_flag_unit #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_flags,
    input  logic [W-1:0] upd,
    input  logic [W-1:0] upd_val,
    output logic [W-1:0] flags_q
);
    logic [W-1:0] flags_d;
    logic         any_upd;

    assign any_upd = |upd;

    always_comb begin
        flags_d = flags_q;
        if (wr_en && !any_upd) flags_d = wr_flags;
        for (int i = 0; i < W; i++) begin
            if (upd[i]) flags_d[i] = upd_val[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= RST_VAL;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/stat_bank_unit.sv
module stat_bank_unit #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_bank,
    output logic [W-1:0] bank_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bank_q <= '0;
        else if (wr_en) bank_q <= wr_bank;
    end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
    import stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [FLAG_W-1:0] flg_upd,
    input  logic [FLAG_W-1:0] flg_val,
    input  logic              wdt_clr,
    input  logic              sleep_evt,
    input  logic              wdt_tmo,
    output logic [REG_W-1:0]  stat_q,
    output logic              ind_bank_hi,
    output logic [1:0]        dir_bank
);
    localparam int FLAG_LO = 0;
    localparam int PD_POS  = FLAG_W;
    localparam int TO_POS  = FLAG_W + 1;
    localparam int BANK_LO = FLAG_W + 2;

    logic [BANK_W-1:0] bank_q;
    logic [FLAG_W-1:0] flags_q;
    logic              to_q;
    logic              pd_q;

    stat_bank_unit #(.W(BANK_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (wr_data[BANK_LO +: BANK_W]),
        .bank_q  (bank_q)
    );

    stat_flag_unit #(.W(FLAG_W), .RST_VAL('0)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_flags (wr_data[FLAG_LO +: FLAG_W]),
        .upd      (flg_upd),
        .upd_val  (flg_val),
        .flags_q  (flags_q)
    );

    stat_pwr_fsm u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdt_clr   (wdt_clr),
        .sleep_evt (sleep_evt),
        .wdt_tmo   (wdt_tmo),
        .to_q      (to_q),
        .pd_q      (pd_q)
    );

    always_comb begin
        stat_q                         = '0;
        stat_q[BANK_LO +: BANK_W]      = bank_q;
        stat_q[TO_POS]                 = to_q;
        stat_q[PD_POS]                 = pd_q;
        stat_q[FLAG_LO +: FLAG_W]      = flags_q;
    end

    assign ind_bank_hi = bank_q[BANK_W-1];
    assign dir_bank    = bank_q[1:0];
endmodule

// File: rtl/stat_reg_chk.sv
module stat_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [2:0] flg_upd,
    input logic [2:0] flg_val,
    input logic       wdt_clr,
    input logic       sleep_evt,
    input logic       wdt_tmo,
    input logic [7:0] stat_q
);
    // R2
    bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> stat_q[7:5] == $past(wr_data[7:5]));

    // R3
    pwr_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_clr && !sleep_evt && !wdt_tmo) |=> $stable(stat_q[4:3]));

    // R4
    flag_unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flg_upd) |=> (stat_q[2:0] & ~$past(flg_upd)) == ($past(stat_q[2:0]) & ~$past(flg_upd)));

    // R5
    flag_masked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flg_upd) |=> (stat_q[2:0] & $past(flg_upd)) == ($past(flg_val) & $past(flg_upd)));

    // R6
    wdt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr && !wdt_tmo) |=> stat_q[4:3] == 2'b11);

    // R7
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_evt && !wdt_clr && !wdt_tmo) |=> stat_q[4:3] == 2'b10);

    // R8
    tmo_clears_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tmo |=> !stat_q[4] && stat_q[3] == $past(stat_q[3]));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && flg_upd == 3'b000 && !wdt_clr && !sleep_evt && !wdt_tmo) |=> $stable(stat_q));
endmodule

bind cpu_status_reg stat_reg_chk u_stat_reg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .flg_upd   (flg_upd),
    .flg_val   (flg_val),
    .wdt_clr   (wdt_clr),
    .sleep_evt (sleep_evt),
    .wdt_tmo   (wdt_tmo),
    .stat_q    (stat_q)
);

// File: tb/test_cpu_status_reg.sv
module test_cpu_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] flg_upd = '0;
    logic [2:0] flg_val = '0;
    logic       wdt_clr = 1'b0;
    logic       sleep_evt = 1'b0;
    logic       wdt_tmo = 1'b0;
    logic [7:0] stat_q;
    logic       ind_bank_hi;
    logic [1:0] dir_bank;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference state
    int m_bank, m_to, m_pd, m_flag;

    always #2.5 clk = ~clk;

    cpu_status_reg i_cpu_status_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .flg_upd(flg_upd), .flg_val(flg_val), .wdt_clr(wdt_clr),
        .sleep_evt(sleep_evt), .wdt_tmo(wdt_tmo), .stat_q(stat_q),
        .ind_bank_hi(ind_bank_hi), .dir_bank(dir_bank)
    );

    function automatic int exp_word();
        return (m_bank << 5) | (m_to << 4) | (m_pd << 3) | m_flag;
    endfunction

    task automatic compare(input string req);
        int e;
        e = exp_word();
        checks++;
        if (stat_q !== e[7:0] || ind_bank_hi !== e[7] || dir_bank !== e[6:5]) begin
            errors++;
            $display("FAIL %s: stat_q=%b hi=%b dir=%b expected %b", req, stat_q,
                     ind_bank_hi, dir_bank, e[7:0]);
        end
    endtask

    task automatic model_edge();
        if (wr_en) m_bank = int'(wr_data[7:5]);
        if (wr_en && flg_upd == 3'b000) m_flag = int'(wr_data[2:0]);
        for (int b = 0; b < 3; b++)
            if (flg_upd[b]) m_flag = (m_flag & ~(1 << b)) | (int'(flg_val[b]) << b);
        if (wdt_tmo) m_to = 0;
        else if (wdt_clr) begin m_to = 1; m_pd = 1; end
        else if (sleep_evt) begin m_to = 1; m_pd = 0; end
    endtask

    task automatic step(input bit we, input logic [7:0] wd, input logic [2:0] mk,
                        input logic [2:0] fv, input bit c, input bit s, input bit t,
                        input string req);
        wr_en = we; wr_data = wd; flg_upd = mk; flg_val = fv;
        wdt_clr = c; sleep_evt = s; wdt_tmo = t;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wr_en = 1'b0; flg_upd = '0; wdt_clr = 1'b0; sleep_evt = 1'b0; wdt_tmo = 1'b0;
        compare(req);
    endtask

    initial begin
        #(5.0 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_bank = 0; m_to = 1; m_pd = 1; m_flag = 0;
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R2 plain write, R10 decode
        step(1, 8'b1010_0101, 3'b000, 3'b000, 0, 0, 0, "R2 write zero mask");
        step(1, 8'b0111_1010, 3'b000, 3'b000, 0, 0, 0, "R10 decode / R3 TO PD ignore bus");
        // R4 clear-register pattern: write 0 with Z update to 1
        step(1, 8'b0000_0000, 3'b100, 3'b100, 0, 0, 0, "R4 clear pattern 000uu1uu");
        // R4 write ones with partial mask
        step(1, 8'hFF, 3'b001, 3'b000, 0, 0, 0, "R4 partial mask bus ignored");
        // R5 update without write
        step(0, 8'hFF, 3'b110, 3'b010, 0, 0, 0, "R5 flag update only");
        // R11 idle
        step(0, 8'h00, 3'b000, 3'b111, 0, 0, 0, "R11 idle hold");
        // events
        step(0, 8'h00, 3'b000, 3'b000, 0, 1, 0, "R7 sleep");
        step(0, 8'h00, 3'b000, 3'b000, 0, 0, 1, "R8 timeout keeps PD low");
        step(0, 8'h00, 3'b000, 3'b000, 1, 0, 0, "R6 clear");
        step(0, 8'h00, 3'b000, 3'b000, 0, 0, 1, "R8 timeout keeps PD high");
        step(0, 8'h00, 3'b000, 3'b000, 1, 0, 0, "R6 clear after timeout");
        step(0, 8'h00, 3'b000, 3'b000, 1, 0, 1, "R8 timeout beats clear");
        step(0, 8'h00, 3'b000, 3'b000, 0, 1, 1, "R8 timeout beats sleep");
        step(0, 8'h00, 3'b000, 3'b000, 1, 1, 0, "R9 clear beats sleep");
        step(1, 8'hFF, 3'b000, 3'b000, 0, 1, 0, "R3 write during sleep");

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[15:8], (r[3:1] == 3'b111) ? 3'b000 : r[18:16] & {3{r[4]}},
                 r[21:19], r[22] & r[23], r[24] & r[25], r[26] & r[27] & r[28],
                 "R11 random model");
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule